// File: doc/BRIEF.md
# Paged Configuration RAM Window

This block lets a processor reach an 8 KB external configuration RAM through an I/O window that is only 256 bytes wide. The RAM is split into 32 pages of 256 bytes. A writable page register, held at its own I/O port, picks the page. When an I/O read or write falls inside the window, the block drives the page number onto the five highest system address lines and pulses a read or a write strobe toward the RAM. The low eight address bits reach the RAM directly from the bus.

A single enable bit, taken from a separate chip-select control register, gates all RAM-side activity. The page register stays writable and readable whether or not the enable is set. The RAM device and the data-bus buffers are outside this block.

Top module: `cfg_ram_pager`

## Requirements
- R1: After reset the page register holds 0, both RAM strobes are high (inactive) and the page-address output enable is low.
- R2: An I/O write (`io_wr_n` low) to address `PAGE_PORT` (default 16'h0C00) loads bits 4:0 of `io_wdata` into the page register on the next rising clock edge. Bits 7:5 of the written value are discarded.
- R3: `page_rdata` shows the page register in bits 4:0, and bits 7:5 always read 0.
- R4: While `enable` is 1 and `io_rd_n` is low with an address in 16'h0800 to 16'h08FF, `ram_rd_n` is low. It is high at all other times.
- R5: While `enable` is 1 and `io_wr_n` is low with an address in 16'h0800 to 16'h08FF, `ram_wr_n` is low. It is high at all other times.
- R6: During an enabled window access `la_oe` is 1 and `la_hi` equals the page register. Outside such an access `la_oe` is 0 and `la_hi` is 0.
- R7: When `enable` is 0, window accesses leave both strobes high and `la_oe` low.
- R8: Writes to the page port update the page register whatever the value of `enable`.
- R9: An address just outside the window (16'h07FF or 16'h0900) asserts no strobe and leaves `la_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | I/O address |
| io_rd_n | input | 1 | I/O read command, active low |
| io_wr_n | input | 1 | I/O write command, active low |
| io_wdata | input | 8 | Write data for the page register |
| enable | input | 1 | Enables the window decode |
| page_rdata | output | 8 | Readback of the page register |
| la_hi | output | 5 | Page number for the upper address lines |
| la_oe | output | 1 | Output enable for `la_hi` |
| ram_rd_n | output | 1 | RAM read strobe, active low |
| ram_wr_n | output | 1 | RAM write strobe, active low |

## Verification
The page register is the only state in the block. If it holds a wrong value, that value appears on `page_rdata` in the same cycle. The wrong value also appears on `la_hi` during the very next enabled window access, so the bench reads the register back after every write and compares `la_hi` inside the window. The strobes and the output enable depend only on the current inputs, so a decode error shows at the ports in the same cycle the stimulus is applied.

// File: rtl/cfg_ram_pager.sv
module cfg_ram_pager #(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          PW        = 5,
  parameter logic [15:0] WIN_BASE  = 16'h0800,
  parameter int          WIN_BITS  = 8,
  parameter logic [15:0] PAGE_PORT = 16'h0C00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_rd_n,
  input  logic          io_wr_n,
  input  logic [DW-1:0] io_wdata,
  input  logic          enable,
  output logic [DW-1:0] page_rdata,
  output logic [PW-1:0] la_hi,
  output logic          la_oe,
  output logic          ram_rd_n,
  output logic          ram_wr_n
);
  localparam int TAGW = AW - WIN_BITS;

  logic [PW-1:0] page_q;
  logic          in_win;
  logic          hit_port;
  logic          win_rd;
  logic          win_wr;

  assign in_win   = io_addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS];
  assign hit_port = io_addr == PAGE_PORT[AW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 page_q <= '0;
    else if (!io_wr_n && hit_port) page_q <= io_wdata[PW-1:0];

  assign win_rd = enable && in_win && !io_rd_n;
  assign win_wr = enable && in_win && !io_wr_n;

  assign ram_rd_n   = !win_rd;
  assign ram_wr_n   = !win_wr;
  assign la_oe      = win_rd || win_wr;
  assign la_hi      = la_oe ? page_q : '0;
  assign page_rdata = {{(DW-PW){1'b0}}, page_q};

  logic unused_tag;
  assign unused_tag = ^TAGW;
endmodule

module cfg_ram_pager_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] io_addr,
  input logic          io_rd_n,
  input logic          io_wr_n,
  input logic [DW-1:0] io_wdata,
  input logic          enable,
  input logic [DW-1:0] page_rdata,
  input logic [PW-1:0] la_hi,
  input logic          la_oe,
  input logic          ram_rd_n,
  input logic          ram_wr_n
);
  AST_PORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr_n && io_addr == 16'h0C00) |=> page_rdata == {3'b000, $past(io_wdata[4:0])}); // R2
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    page_rdata[7:5] == 3'b000); // R3
  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rd_n |-> (enable && !io_rd_n && io_addr[15:8] == 8'h08)); // R4
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_wr_n |-> (enable && !io_wr_n && io_addr[15:8] == 8'h08)); // R5
  AST_PAGE_ON_LA: assert property (@(posedge clk) disable iff (!rst_n)
    la_oe |-> la_hi == page_rdata[4:0]); // R6
  AST_OE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    la_oe == (!ram_rd_n || !ram_wr_n)); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (ram_rd_n && ram_wr_n && !la_oe)); // R7
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(!io_wr_n && io_addr == 16'h0C00) |=> $stable(page_rdata)); // R8
endmodule

bind cfg_ram_pager cfg_ram_pager_chk #(.AW(AW), .DW(DW), .PW(PW)) i_chk (.*);

// File: tb/test_cfg_ram_pager.sv
module test_cfg_ram_pager;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = '0;
  logic io_rd_n = 1, io_wr_n = 1;
  logic [7:0] io_wdata = '0;
  logic enable = 0;
  logic [7:0] page_rdata;
  logic [4:0] la_hi;
  logic la_oe, ram_rd_n, ram_wr_n;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_ram_pager i_cfg_ram_pager (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    io_rd_n = 1; io_wr_n = 1;
  endtask

  task automatic write_page(logic [7:0] d);
    @(negedge clk); io_addr = 16'h0C00; io_wdata = d; io_wr_n = 0;
    @(negedge clk); idle();
  endtask

  task automatic probe(logic [15:0] a, bit rd, string req,
                       logic exp_rd_n, logic exp_wr_n, logic exp_oe, logic [4:0] exp_la);
    @(negedge clk); io_addr = a;
    if (rd) io_rd_n = 0; else io_wr_n = 0;
    #1;
    chk({req, " ram_rd_n"}, ram_rd_n, exp_rd_n);
    chk({req, " ram_wr_n"}, ram_wr_n, exp_wr_n);
    chk({req, " la_oe"}, la_oe, exp_oe);
    chk({req, " la_hi"}, la_hi, exp_la);
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 page", page_rdata, 8'h00);
    chk("R1 rd", ram_rd_n, 1'b1);
    chk("R1 wr", ram_wr_n, 1'b1);
    chk("R1 oe", la_oe, 1'b0);
  endtask

  task automatic t_page_write();
    write_page(8'hFF);
    chk("R2 R3 mask", page_rdata, 8'h1F);
    write_page(8'h0A);
    chk("R2 load", page_rdata, 8'h0A);
    write_page(8'hE3);
    chk("R3 high bits", page_rdata, 8'h03);
  endtask

  task automatic t_window();
    enable = 1;
    write_page(8'h15);
    probe(16'h0800, 1, "R4 R6 rd low",  0, 1, 1, 5'h15);
    probe(16'h08FF, 1, "R4 rd high",    0, 1, 1, 5'h15);
    probe(16'h0842, 0, "R5 R6 wr",      1, 0, 1, 5'h15);
    probe(16'h0C00, 1, "R6 port rd",    1, 1, 0, 5'h00);
    write_page(8'h1F);
    probe(16'h08A0, 0, "R6 new page",   1, 0, 1, 5'h1F);
    chk("R5 window write no page change", page_rdata, 8'h1F);
  endtask

  task automatic t_edges();
    enable = 1;
    probe(16'h07FF, 1, "R9 below rd", 1, 1, 0, 5'h00);
    probe(16'h0900, 0, "R9 above wr", 1, 1, 0, 5'h00);
    probe(16'h1800, 1, "R9 alias",    1, 1, 0, 5'h00);
  endtask

  task automatic t_disabled();
    enable = 0;
    probe(16'h0810, 1, "R7 rd", 1, 1, 0, 5'h00);
    probe(16'h0810, 0, "R7 wr", 1, 1, 0, 5'h00);
    write_page(8'h07);
    chk("R8 write while disabled", page_rdata, 8'h07);
    enable = 1;
    probe(16'h0810, 1, "R8 page used", 0, 1, 1, 5'h07);
  endtask

  initial begin
    fork
      begin
        #1; t_reset();
        #(3*CLK_PERIOD); rst_n = 1;
        t_page_write();
        t_window();
        t_edges();
        t_disabled();
      end
      begin
        #(20000*CLK_PERIOD);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule